// File: doc/BRIEF.md
# GPIO Bank with Grouped Interrupts

A bank of up to 32 general-purpose lines behind a small register bus. Each line can be an input or an output. An output line drives a stored data bit, and that bit can be made to blink from a free-running divider. Every input passes through a two-stage synchronizer. A per-line polarity bit then inverts it or leaves it alone, and the result is the data-in value that both interrupt paths see.

Two interrupt sources exist per line. The level source is data-in gated by a level mask. The edge source is a sticky latch that records a 0-to-1 change of data-in and is gated by an edge mask. The two gated sources are ORed per line, and lines are ORed in groups of eight onto summary outputs. Falling-edge triggering uses the same rising latch with the polarity bit set. Both-edge triggering works the same way, with software flipping the polarity after each event.

An optional second CPU view adds its own edge and level masks. These drive a second set of summary outputs from the same data-in and edge latches.

Top module: `gpio_bank`

## Requirements
- R1: After reset the direction register (offset 0x04) reads all ones and every other register reads zero. Output enables and all summary interrupts are low.
- R2: A direction bit of 1 makes the line an input, with pin_oe_o low. A bit of 0 makes it an output, with pin_oe_o high and pin_out_o carrying the output data bit (offset 0x00). The new setting appears the cycle after the write.
- R3: Reading offset 0x10 returns the synchronized pin level XOR the polarity bit (offset 0x0C). A pin change becomes visible after the second rising clock edge.
- R4: An edge cause bit (offset 0x14) sets when its data-in bit goes from 0 to 1, one edge after data-in changes. It stays set until software clears it. Setting the polarity bit turns a falling pin into a recorded event.
- R5: A write to offset 0x14 clears each cause bit written as 0 and keeps each bit written as 1. An event arriving in the same cycle as a clearing write leaves its bit set.
- R6: A line's level source is its data-in bit ANDed with the level mask (offset 0x1C for CPU0). It follows data-in with no latching.
- R7: The per-line cause is (data-in AND level mask) OR (edge cause AND edge mask). Summary output g is the OR over lines 8g to 8g+7. With both masks zero, every summary output is low.
- R8: With DUAL_CPU set, offsets 0x30 (edge mask) and 0x34 (level mask) belong to CPU1 and drive only irq_cpu1_o. Offsets 0x18 and 0x1C drive only irq_cpu0_o.
- R9: For an output line whose blink bit (offset 0x08) is set, pin_out_o is the data bit XOR bit BLINK_DIV_W-1 of a counter. The counter starts at 0 after reset and counts every clock. With the blink bit clear, the pin holds the data bit steady.
- R10: Offsets 0x00, 0x04, 0x08, 0x0C, 0x18, 0x1C, 0x30 and 0x34 read back what was written. Unmapped offsets read zero. Writes to 0x10 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| pin_in_i | input | NUM_LINES | Raw pin levels |
| pin_out_o | output | NUM_LINES | Driven pin values |
| pin_oe_o | output | NUM_LINES | Output enables, high for output lines |
| irq_cpu0_o | output | NUM_GROUPS | CPU0 summary interrupts, one per group of eight lines |
| irq_cpu1_o | output | NUM_GROUPS | CPU1 summary interrupts, zero when DUAL_CPU is 0 |

## Verification
The assertions assume that the bus holds addr_i and wdata_i stable around each clock edge while wr_en_i is high. They also assume that pin inputs move only between edges, so the synchronizer sees a clean level. The stimulus drives every bus and pin change on the falling clock edge and holds it through the next rising edge. It times each same-cycle collision, such as a clearing write landing on a new edge event, by counting rising edges from the pin change.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int ADDR_W = 8;
  localparam int BUS_W  = 32;

  localparam logic [ADDR_W-1:0] OFS_DOUT   = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_DIR    = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_BLINK  = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_POL    = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_DIN    = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_ECAUSE = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_EMASK0 = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_LMASK0 = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_EMASK1 = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_LMASK1 = 8'h34;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_edge_latch.sv
module gpio_edge_latch #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] din_i,
  input  logic         clr_en_i,
  input  logic [W-1:0] keep_i,
  output logic [W-1:0] cause_o
);
  logic [W-1:0] prev_q, cause_q, rise;

  assign rise = din_i & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      cause_q <= '0;
    end else begin
      prev_q  <= din_i;
      // new events win over a clearing write in the same cycle
      cause_q <= (clr_en_i ? (cause_q & keep_i) : cause_q) | rise;
    end
  end

  assign cause_o = cause_q;

  // R4
  cause_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_en_i |=> ((cause_q & $past(cause_q)) == $past(cause_q)));

  // R5
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise != '0) |=> ((cause_q & $past(rise)) == $past(rise)));
endmodule

// File: rtl/gpio_irq_gate.sv
module gpio_irq_gate #(
  parameter int W          = 32,
  parameter int GROUP_SIZE = 8,
  localparam int NUM_GROUPS = (W + GROUP_SIZE - 1) / GROUP_SIZE
) (
  input  logic [W-1:0]          din_i,
  input  logic [W-1:0]          ecause_i,
  input  logic [W-1:0]          emask_i,
  input  logic [W-1:0]          lmask_i,
  output logic [NUM_GROUPS-1:0] irq_o
);
  logic [W-1:0] line;

  assign line = (din_i & lmask_i) | (ecause_i & emask_i);

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    localparam int LO = g * GROUP_SIZE;
    localparam int HI = (LO + GROUP_SIZE > W) ? W - 1 : LO + GROUP_SIZE - 1;
    assign irq_o[g] = |line[HI:LO];
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int NUM_LINES   = 32,
  parameter int GROUP_SIZE  = 8,
  parameter bit DUAL_CPU    = 1'b0,
  parameter int BLINK_DIV_W = 24,
  localparam int NUM_GROUPS = (NUM_LINES + GROUP_SIZE - 1) / GROUP_SIZE
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [BUS_W-1:0]      wdata_i,
  output logic [BUS_W-1:0]      rdata_o,
  input  logic [NUM_LINES-1:0]  pin_in_i,
  output logic [NUM_LINES-1:0]  pin_out_o,
  output logic [NUM_LINES-1:0]  pin_oe_o,
  output logic [NUM_GROUPS-1:0] irq_cpu0_o,
  output logic [NUM_GROUPS-1:0] irq_cpu1_o
);
  logic [NUM_LINES-1:0] wd;
  logic [NUM_LINES-1:0] dout_q, dir_q, blink_q, pol_q, emask0_q, lmask0_q;
  logic [NUM_LINES-1:0] emask1_q, lmask1_q;
  logic [NUM_LINES-1:0] sync_w, din, ecause, rd_val;
  logic [BLINK_DIV_W-1:0] div_q;
  logic tog;
  logic ecause_clr;

  assign wd = wdata_i[NUM_LINES-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q   <= '0;
      dir_q    <= '1;
      blink_q  <= '0;
      pol_q    <= '0;
      emask0_q <= '0;
      lmask0_q <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        OFS_DOUT:   dout_q   <= wd;
        OFS_DIR:    dir_q    <= wd;
        OFS_BLINK:  blink_q  <= wd;
        OFS_POL:    pol_q    <= wd;
        OFS_EMASK0: emask0_q <= wd;
        OFS_LMASK0: lmask0_q <= wd;
        default: ;
      endcase
    end
  end

  if (DUAL_CPU) begin : g_cpu1
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        emask1_q <= '0;
        lmask1_q <= '0;
      end else if (wr_en_i) begin
        if (addr_i == OFS_EMASK1) emask1_q <= wd;
        if (addr_i == OFS_LMASK1) lmask1_q <= wd;
      end
    end
  end else begin : g_no_cpu1
    assign emask1_q = '0;
    assign lmask1_q = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_q + 1'b1;
  end

  assign tog       = div_q[BLINK_DIV_W-1];
  assign pin_out_o = dout_q ^ (blink_q & {NUM_LINES{tog}});
  assign pin_oe_o  = ~dir_q;

  gpio_sync #(.W(NUM_LINES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_in_i),
    .q_o    (sync_w)
  );

  assign din        = sync_w ^ pol_q;
  assign ecause_clr = wr_en_i && (addr_i == OFS_ECAUSE);

  gpio_edge_latch #(.W(NUM_LINES)) u_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .din_i    (din),
    .clr_en_i (ecause_clr),
    .keep_i   (wd),
    .cause_o  (ecause)
  );

  gpio_irq_gate #(.W(NUM_LINES), .GROUP_SIZE(GROUP_SIZE)) u_gate0 (
    .din_i    (din),
    .ecause_i (ecause),
    .emask_i  (emask0_q),
    .lmask_i  (lmask0_q),
    .irq_o    (irq_cpu0_o)
  );

  gpio_irq_gate #(.W(NUM_LINES), .GROUP_SIZE(GROUP_SIZE)) u_gate1 (
    .din_i    (din),
    .ecause_i (ecause),
    .emask_i  (emask1_q),
    .lmask_i  (lmask1_q),
    .irq_o    (irq_cpu1_o)
  );

  // R6
  level_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((din & lmask0_q) != '0) |-> (irq_cpu0_o != '0));

  // R7
  masked_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (emask0_q == '0 && lmask0_q == '0) |-> (irq_cpu0_o == '0));

  always_comb begin
    rd_val = '0;
    case (addr_i)
      OFS_DOUT:   rd_val = dout_q;
      OFS_DIR:    rd_val = dir_q;
      OFS_BLINK:  rd_val = blink_q;
      OFS_POL:    rd_val = pol_q;
      OFS_DIN:    rd_val = din;
      OFS_ECAUSE: rd_val = ecause;
      OFS_EMASK0: rd_val = emask0_q;
      OFS_LMASK0: rd_val = lmask0_q;
      OFS_EMASK1: rd_val = emask1_q;
      OFS_LMASK1: rd_val = lmask1_q;
      default:    rd_val = '0;
    endcase
  end

  assign rdata_o = BUS_W'(rd_val);

  // R2
  dir_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFS_DIR) |=> (pin_oe_o == ~$past(wd)));
endmodule

// File: tb/gpio_bank_tb.sv
module gpio_bank_tb;
  localparam int BW = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe;
  logic [3:0]  irq0, irq1;

  always #5 clk = ~clk;

  gpio_bank #(.NUM_LINES(32), .GROUP_SIZE(8), .DUAL_CPU(1'b1), .BLINK_DIV_W(BW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .pin_in_i(pin_in), .pin_out_o(pin_out), .pin_oe_o(pin_oe),
    .irq_cpu0_o(irq0), .irq_cpu1_o(irq1)
  );

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // behavioural reference state
  logic [31:0] m_dout, m_dir, m_blink, m_pol, m_cause, m_em0, m_lm0, m_em1, m_lm1;
  logic [31:0] m_pipe [2];
  logic [31:0] m_last;
  int unsigned m_cnt;

  function automatic logic [31:0] m_din();
    return m_pipe[1] ^ m_pol;
  endfunction

  function automatic logic [31:0] exp_out();
    logic [31:0] t;
    t = ((m_cnt >> (BW - 1)) & 1) != 0 ? 32'hFFFF_FFFF : 32'h0;
    return m_dout ^ (m_blink & t);
  endfunction

  function automatic logic [31:0] exp_irq(logic [31:0] em, logic [31:0] lm);
    logic [31:0] r;
    r = '0;
    for (int i = 0; i < 32; i++)
      if ((m_din()[i] && lm[i]) || (m_cause[i] && em[i])) r[i / 8] = 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] exp_rd(logic [7:0] a);
    case (a)
      8'h00: return m_dout;
      8'h04: return m_dir;
      8'h08: return m_blink;
      8'h0C: return m_pol;
      8'h10: return m_din();
      8'h14: return m_cause;
      8'h18: return m_em0;
      8'h1C: return m_lm0;
      8'h30: return m_em1;
      8'h34: return m_lm1;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin : mdl
    logic [31:0] dnow, kept;
    if (!rst_n) begin
      m_dout <= '0; m_dir <= '1; m_blink <= '0; m_pol <= '0; m_cause <= '0;
      m_em0 <= '0; m_lm0 <= '0; m_em1 <= '0; m_lm1 <= '0;
      m_pipe[0] <= '0; m_pipe[1] <= '0; m_last <= '0; m_cnt <= 0;
    end else begin
      dnow = m_din();
      kept = (wr_en && addr == 8'h14) ? (m_cause & wdata) : m_cause;
      m_cause   <= kept | (dnow & ~m_last);
      m_last    <= dnow;
      m_pipe[0] <= pin_in;
      m_pipe[1] <= m_pipe[0];
      m_cnt     <= m_cnt + 1;
      if (wr_en) begin
        if (addr == 8'h00) m_dout  <= wdata;
        if (addr == 8'h04) m_dir   <= wdata;
        if (addr == 8'h08) m_blink <= wdata;
        if (addr == 8'h0C) m_pol   <= wdata;
        if (addr == 8'h18) m_em0   <= wdata;
        if (addr == 8'h1C) m_lm0   <= wdata;
        if (addr == 8'h30) m_em1   <= wdata;
        if (addr == 8'h34) m_lm1   <= wdata;
      end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(posedge clk) begin
    if (rst_n && !done) begin
      #3;
      check("R2 oe per cycle", pin_oe, ~m_dir);
      check("R9 pin_out per cycle", pin_out, exp_out());
      check("R7 irq_cpu0 per cycle", {28'b0, irq0}, exp_irq(m_em0, m_lm0));
      check("R8 irq_cpu1 per cycle", {28'b0, irq1}, exp_irq(m_em1, m_lm1));
      check("R10 rdata per cycle", rdata, exp_rd(addr));
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(logic [7:0] a, logic [31:0] exp, string tag);
    addr = a;
    #1;
    check(tag, rdata, exp);
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic p;
    int flips;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);

    // R1 reset state
    rd_chk(8'h04, 32'hFFFF_FFFF, "R1 dir reset");
    rd_chk(8'h00, 32'h0, "R1 dout reset");
    rd_chk(8'h08, 32'h0, "R1 blink reset");
    rd_chk(8'h0C, 32'h0, "R1 pol reset");
    rd_chk(8'h14, 32'h0, "R1 cause reset");
    rd_chk(8'h1C, 32'h0, "R1 lmask reset");
    rd_chk(8'h34, 32'h0, "R1 cpu1 lmask reset");
    check("R1 oe reset", pin_oe, 32'h0);
    check("R1 irq reset", {24'b0, irq1, irq0}, 32'h0);

    // R2 direction and output data
    wr(8'h04, 32'hFFFF_0000);
    wr(8'h00, 32'h0000_A5C3);
    #1;
    check("R2 oe", pin_oe, 32'h0000_FFFF);
    check("R2 out", pin_out & 32'h0000_FFFF, 32'h0000_A5C3);

    // R3 synchronized data-in and polarity
    pin_in = 32'h1234_0000;
    wait_n(1);
    rd_chk(8'h10, 32'h0, "R3 not yet after one edge");
    wait_n(1);
    rd_chk(8'h10, 32'h1234_0000, "R3 data-in");
    wait_n(1);
    rd_chk(8'h14, 32'h1234_0000, "R4 rising edges latched");
    wr(8'h0C, 32'hFFFF_0000);
    rd_chk(8'h10, 32'hEDCB_0000, "R3 polarity inverts");
    wait_n(1);
    rd_chk(8'h14, 32'hFFFF_0000, "R4 polarity-induced rises");

    wr(8'h0C, 32'h0);
    pin_in = 32'h0;
    wait_n(4);
    wr(8'h14, 32'h0);
    rd_chk(8'h14, 32'h0, "R5 clear all");

    // R4 rising edge timing and stickiness
    pin_in = 32'h0001_0000;
    wait_n(2);
    rd_chk(8'h14, 32'h0, "R4 cause not before third edge");
    wait_n(1);
    rd_chk(8'h14, 32'h0001_0000, "R4 cause set");
    pin_in = 32'h0;
    wait_n(4);
    rd_chk(8'h14, 32'h0001_0000, "R4 cause sticky");

    // R5 write-zero-to-clear
    wr(8'h14, 32'hFFFF_FFFF);
    rd_chk(8'h14, 32'h0001_0000, "R5 ones keep");
    wr(8'h14, 32'hFFFE_FFFF);
    rd_chk(8'h14, 32'h0, "R5 zero clears");

    // R5 event and clear in the same cycle
    pin_in = 32'h0002_0000;
    wait_n(2);
    wr_en = 1'b1; addr = 8'h14; wdata = 32'h0;
    wait_n(1);
    wr_en = 1'b0;
    rd_chk(8'h14, 32'h0002_0000, "R5 set wins over clear");
    wr(8'h14, 32'h0);
    rd_chk(8'h14, 32'h0, "R5 clear after collision");

    // R4 falling edge through polarity
    pin_in = 32'h0012_0000;
    wait_n(4);
    wr(8'h0C, 32'h0010_0000);
    wait_n(2);
    wr(8'h14, 32'h0);
    pin_in = 32'h0002_0000;
    wait_n(2);
    rd_chk(8'h14, 32'h0, "R4 falling not yet");
    wait_n(1);
    rd_chk(8'h14, 32'h0010_0000, "R4 falling via polarity");

    // R6 / R8 level masks per CPU
    wr(8'h0C, 32'h0);
    pin_in = 32'h0102_0000;
    wait_n(4);
    wr(8'h1C, 32'h0100_0000);
    #1;
    check("R6 level irq cpu0", {28'b0, irq0}, 32'h8);
    check("R8 cpu1 unaffected", {28'b0, irq1}, 32'h0);
    wr(8'h34, 32'h0100_0000);
    #1;
    check("R8 cpu1 level irq", {28'b0, irq1}, 32'h8);
    wr(8'h1C, 32'h0);
    #1;
    check("R6 level masked", {28'b0, irq0}, 32'h0);
    check("R8 cpu1 keeps level", {28'b0, irq1}, 32'h8);

    // R7 / R8 edge masks: cause holds bits 20 and 24
    rd_chk(8'h14, 32'h0110_0000, "R4 cause bits 20 and 24");
    wr(8'h30, 32'h0010_0000);
    #1;
    check("R8 cpu1 edge plus level", {28'b0, irq1}, 32'hC);
    wr(8'h18, 32'h0010_0000);
    #1;
    check("R7 cpu0 edge group2", {28'b0, irq0}, 32'h4);

    // R7 group boundaries
    wr(8'h18, 32'h0); wr(8'h30, 32'h0); wr(8'h34, 32'h0);
    pin_in = 32'h0000_0100;
    wait_n(3);
    wr(8'h1C, 32'h0000_FFFF);
    #1;
    check("R7 line 8 to group1", {28'b0, irq0}, 32'h2);
    pin_in = 32'h0000_0080;
    wait_n(3);
    check("R7 line 7 to group0", {28'b0, irq0}, 32'h1);
    check("R8 cpu1 quiet", {28'b0, irq1}, 32'h0);

    // R9 blink
    wr(8'h08, 32'h0000_0001);
    p = pin_out[0];
    flips = 0;
    for (int i = 0; i < 16; i++) begin
      wait_n(1);
      if (pin_out[0] !== p) flips++;
      p = pin_out[0];
    end
    check("R9 blink transitions", 32'(flips), 32'd4);
    wr(8'h08, 32'h0);
    flips = 0;
    for (int i = 0; i < 8; i++) begin
      wait_n(1);
      if (pin_out[0] !== 1'b1) flips++;
    end
    check("R9 steady without blink", 32'(flips), 32'd0);

    // R10 readback, unmapped, data-in not writable
    rd_chk(8'h20, 32'h0, "R10 unmapped");
    wr(8'h10, 32'hFFFF_FFFF);
    rd_chk(8'h10, 32'h0000_0080, "R10 data-in write ignored");
    wr(8'h0C, 32'h5A5A_0000);
    rd_chk(8'h0C, 32'h5A5A_0000, "R10 pol readback");
    wr(8'h34, 32'h1357_9BDF);
    rd_chk(8'h34, 32'h1357_9BDF, "R10 cpu1 lmask readback");
    rd_chk(8'h00, 32'h0000_A5C3, "R10 dout readback");
    rd_chk(8'h1C, 32'h0000_FFFF, "R10 lmask readback");

    wait_n(2);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule